// File: doc/BRIEF.md
# Interrupt Source Controller with Sensing Options

This block gathers interrupt requests from peripherals and external pins into four maskable vectors and one non-maskable vector. It then presents one request line per vector to a small CPU core, raising only the highest-priority request at a time. A write-only option byte selects three things:

- whether vector 1 is level- or edge-sensed;
- which edge of the port pins feeding vector 2 is active;
- whether the maskable vectors may reach the core at all.

Each peripheral request carries its own enable input. Requests on the external pins and on the non-maskable input pass through a two-flop synchronizer, then a registered previous-value compare. Edge events latch a pending flag per vector, which the core clears with a one-hot acknowledge pulse. A wake-up output tells the power controller that a pending request should end a stop or wait state. It stays low whenever the global enable is off, even for the non-maskable vector.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset the option byte is 0x00, `pend_vec`, `irq_req` and `wake` are all zero.
- R2: The option byte changes only on a cycle with `wr_en`=1, `wr_full`=1 and `wr_addr`=0xC8. Bit 6 selects the vector-1 sense mode, bit 5 the vector-2 polarity and bit 4 the global enable; bits 7 and 3..0 are ignored. A write with `wr_full`=0 or any other address has no effect.
- R3: With bit 6 set, `pend_vec[1]` equals `src1_req & src1_en` in the same cycle, with no latch.
- R4: With bit 6 clear, a rising edge of `src1_req & src1_en` sets `pend_vec[1]` at the next clock edge, and it stays set until acknowledged.
- R5: Each pin of `pin_in` is synchronized by two flops and compared with its previous synchronized value. Bit 5 = 1 selects rising edges and bit 5 = 0 selects falling edges. An active edge on a pin whose `pin_en` bit is 1 sets `pend_vec[2]` at the third clock edge after the pin changes. Pins with `pin_en` = 0 are ignored.
- R6: A rising edge of any `s3_req & s3_en` bit sets `pend_vec[3]`, and of any `s4_req & s4_en` bit sets `pend_vec[4]`, at the first clock edge that samples it.
- R7: An `ack_vec` bit (bit n for vector n) clears that latched pending flag at the next clock edge. A new edge for the same vector in the same cycle wins, and the flag stays set.
- R8: A rising edge on `nmi_in`, after the two-flop synchronizer, sets `pend_vec[0]` whatever the option byte holds. `irq_req[0]` follows `pend_vec[0]`.
- R9: With bit 4 clear, `irq_req[4:1]` stay zero while pending flags still latch. Setting bit 4 later releases them.
- R10: `irq_req` is one-hot or zero. It marks the lowest-numbered eligible vector, so vector 0 has the highest priority and vector 4 the lowest.
- R11: `wake` is 1 exactly when bit 4 is set and any `pend_vec` bit is set, so it stays 0 whenever bit 4 is clear, including for vector 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_full | input | 1 | 1 = full-byte write, 0 = single-bit operation |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| nmi_in | input | 1 | Non-maskable request input, rising edge |
| src1_req | input | 1 | Vector-1 request (serial end of transfer) |
| src1_en | input | 1 | Local enable for `src1_req` |
| pin_in | input | NUM_PINS | External port pins feeding vector 2 |
| pin_en | input | NUM_PINS | Per-pin enables |
| s3_req | input | NUM_S3 | Timer, oscillator and auto-reload timer event lines |
| s3_en | input | NUM_S3 | Enables for `s3_req` |
| s4_req | input | NUM_S4 | Converter and UART event lines |
| s4_en | input | NUM_S4 | Enables for `s4_req` |
| ack_vec | input | 5 | One-hot acknowledge per vector |
| pend_vec | output | 5 | Pending flag per vector |
| irq_req | output | 5 | One-hot request to the core |
| wake | output | 1 | Wake-up request for low-power modes |

## Verification
On every cycle the assertions check four things: the request output is one-hot or zero; masked vectors and `wake` stay low while the global enable is clear; latched flags hold until acknowledged; and the option byte is untouched by writes it must ignore. The bench scenarios are the only way to show the exact cycle in which synchronized edges appear, the choice of edge polarity, the ignoring of disabled pins, the set-beats-acknowledge collision and the release of flags that latched while masked.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
    localparam int NUM_VEC  = 5;
    localparam int VEC_NMI  = 0;
    localparam int VEC_S1   = 1;
    localparam int VEC_PIN  = 2;
    localparam int VEC_S3   = 3;
    localparam int VEC_S4   = 4;

    localparam logic [7:0] OPT_ADDR = 8'hC8;
    localparam int BIT_LVL1 = 6;
    localparam int BIT_POL2 = 5;
    localparam int BIT_GEN  = 4;

    typedef enum logic { S1_EDGE = 1'b0, S1_LEVEL = 1'b1 } s1_mode_e;
    typedef enum logic { POL_FALL = 1'b0, POL_RISE = 1'b1 } pin_pol_e;

    typedef struct packed {
        s1_mode_e s1_mode;
        pin_pol_e pin_pol;
        logic     gen;
    } opt_t;
endpackage

// File: rtl/irq_opt_reg.sv
module irq_opt_reg
    import irq_src_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_full,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output opt_t       opt
);
    logic hit;
    logic unused_bits;

    assign hit         = wr_en && wr_full && (wr_addr == OPT_ADDR);
    assign unused_bits = ^{wr_data[7], wr_data[3:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opt <= '{s1_mode: S1_EDGE, pin_pol: POL_FALL, gen: 1'b0};
        end else if (hit) begin
            opt.s1_mode <= s1_mode_e'(wr_data[BIT_LVL1]);
            opt.pin_pol <= pin_pol_e'(wr_data[BIT_POL2]);
            opt.gen     <= wr_data[BIT_GEN];
        end
    end

    // R2
    opt_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || !wr_full || wr_addr != OPT_ADDR) |=> $stable(opt));
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int WIDTH       = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sig_in,
    input  logic             rise_sel,
    output logic [WIDTH-1:0] edge_out
);
    logic [WIDTH-1:0] cur;
    logic [WIDTH-1:0] prev;

    generate
        if (SYNC_STAGES > 0) begin : g_sync
            logic [WIDTH-1:0] stg [SYNC_STAGES];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
                end else begin
                    stg[0] <= sig_in;
                    for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
                end
            end
            assign cur = stg[SYNC_STAGES-1];
        end else begin : g_direct
            assign cur = sig_in;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= cur;
    end

    assign edge_out = rise_sel ? (cur & ~prev) : (~cur & prev);

    // R5
    edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_out) |=> (prev != $past(prev)));
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
    import irq_src_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] set_vec,
    input  logic [NUM_VEC-1:0] ack_vec,
    input  logic               s1_level,
    input  logic               s1_level_val,
    output logic [NUM_VEC-1:0] pend
);
    logic [NUM_VEC-1:0] latch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            for (int v = 0; v < NUM_VEC; v++) begin
                if (set_vec[v])      latch_q[v] <= 1'b1;
                else if (ack_vec[v]) latch_q[v] <= 1'b0;
            end
            if (s1_level) latch_q[VEC_S1] <= 1'b0;
        end
    end

    always_comb begin
        pend         = latch_q;
        pend[VEC_S1] = s1_level ? s1_level_val : latch_q[VEC_S1];
    end

    generate
        for (genvar v = 0; v < NUM_VEC; v++) begin : g_chk
            if (v != VEC_S1) begin : g_latched
                // R7
                pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (latch_q[v] && !ack_vec[v]) |=> latch_q[v]);
                // R7
                ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (ack_vec[v] && !set_vec[v]) |=> !latch_q[v]);
            end
        end
    endgenerate
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
    import irq_src_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int NUM_S3      = 5,
    parameter int NUM_S4      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_full,
    input  logic [7:0]          wr_addr,
    input  logic [7:0]          wr_data,
    input  logic                nmi_in,
    input  logic                src1_req,
    input  logic                src1_en,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] pin_en,
    input  logic [NUM_S3-1:0]   s3_req,
    input  logic [NUM_S3-1:0]   s3_en,
    input  logic [NUM_S4-1:0]   s4_req,
    input  logic [NUM_S4-1:0]   s4_en,
    input  logic [4:0]          ack_vec,
    output logic [4:0]          pend_vec,
    output logic [4:0]          irq_req,
    output logic                wake
);
    opt_t                opt;
    logic                nmi_edge;
    logic                s1_edge;
    logic [NUM_PINS-1:0] pin_edge;
    logic [NUM_S3-1:0]   s3_edge;
    logic [NUM_S4-1:0]   s4_edge;
    logic [NUM_VEC-1:0]  set_vec;
    logic [NUM_VEC-1:0]  eligible;
    logic                s1_gated;

    irq_opt_reg u_opt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_full(wr_full),
        .wr_addr(wr_addr), .wr_data(wr_data), .opt(opt)
    );

    irq_edge_det #(.WIDTH(1), .SYNC_STAGES(SYNC_STAGES)) u_nmi_det (
        .clk(clk), .rst_n(rst_n), .sig_in(nmi_in), .rise_sel(1'b1), .edge_out(nmi_edge)
    );

    irq_edge_det #(.WIDTH(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_pin_det (
        .clk(clk), .rst_n(rst_n), .sig_in(pin_in),
        .rise_sel(opt.pin_pol == POL_RISE), .edge_out(pin_edge)
    );

    assign s1_gated = src1_req & src1_en;

    irq_edge_det #(.WIDTH(1), .SYNC_STAGES(0)) u_s1_det (
        .clk(clk), .rst_n(rst_n), .sig_in(s1_gated), .rise_sel(1'b1), .edge_out(s1_edge)
    );

    irq_edge_det #(.WIDTH(NUM_S3), .SYNC_STAGES(0)) u_s3_det (
        .clk(clk), .rst_n(rst_n), .sig_in(s3_req & s3_en), .rise_sel(1'b1), .edge_out(s3_edge)
    );

    irq_edge_det #(.WIDTH(NUM_S4), .SYNC_STAGES(0)) u_s4_det (
        .clk(clk), .rst_n(rst_n), .sig_in(s4_req & s4_en), .rise_sel(1'b1), .edge_out(s4_edge)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[VEC_NMI] = nmi_edge;
        set_vec[VEC_S1]  = s1_edge;
        set_vec[VEC_PIN] = |(pin_edge & pin_en);
        set_vec[VEC_S3]  = |s3_edge;
        set_vec[VEC_S4]  = |s4_edge;
    end

    irq_pend_bank u_pend (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .ack_vec(ack_vec),
        .s1_level(opt.s1_mode == S1_LEVEL), .s1_level_val(s1_gated), .pend(pend_vec)
    );

    always_comb begin
        eligible          = pend_vec & {{(NUM_VEC-1){opt.gen}}, 1'b1};
        irq_req           = '0;
        for (int v = NUM_VEC-1; v >= 0; v--) begin
            if (eligible[v]) irq_req = 5'(1) << v;
        end
        wake = opt.gen & (|pend_vec);
    end

    // R10
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_req));
    // R9
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !opt.gen |-> (irq_req[4:1] == 4'b0));
    // R11
    wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !opt.gen |-> !wake);
    // R8
    nmi_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vec[0] |-> irq_req[0]);
endmodule

// File: tb/irq_src_ctrl_test.sv
module irq_src_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_full = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0;
    logic       nmi_in = 1'b0, src1_req = 1'b0, src1_en = 1'b0;
    logic [7:0] pin_in = '0, pin_en = '0;
    logic [4:0] s3_req = '0, s3_en = '0;
    logic [2:0] s4_req = '0, s4_en = '0;
    logic [4:0] ack_vec = '0;
    logic [4:0] pend_vec, irq_req;
    logic       wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_src_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_full(wr_full),
        .wr_addr(wr_addr), .wr_data(wr_data), .nmi_in(nmi_in),
        .src1_req(src1_req), .src1_en(src1_en), .pin_in(pin_in), .pin_en(pin_en),
        .s3_req(s3_req), .s3_en(s3_en), .s4_req(s4_req), .s4_en(s4_en),
        .ack_vec(ack_vec), .pend_vec(pend_vec), .irq_req(irq_req), .wake(wake)
    );

    // entry: {fire mask[11:7], gen[6], expected irq_req[5:1], expected wake[0]}
    localparam logic [11:0] TBL [8] = '{
        {5'b00001, 1'b1, 5'b00001, 1'b1},
        {5'b00110, 1'b1, 5'b00010, 1'b1},
        {5'b11000, 1'b1, 5'b01000, 1'b1},
        {5'b10000, 1'b1, 5'b10000, 1'b1},
        {5'b11111, 1'b1, 5'b00001, 1'b1},
        {5'b11110, 1'b0, 5'b00000, 1'b0},
        {5'b00001, 1'b0, 5'b00001, 1'b0},
        {5'b10100, 1'b1, 5'b00100, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        nmi_in = 0; src1_req = 0; pin_in = '0; s3_req = '0; s4_req = '0; ack_vec = '0;
        src1_en = 1; pin_en = 8'h01; s3_en = '1; s4_en = '1; wr_en = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic full);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d; wr_full = full;
        @(negedge clk);
        wr_en = 0; wr_full = 0;
    endtask

    task automatic fire(input logic [4:0] m);
        @(negedge clk);
        nmi_in = m[0]; src1_req = m[1]; pin_in[0] = m[2]; s3_req[0] = m[3]; s4_req[0] = m[4];
        repeat (3) @(negedge clk);
        nmi_in = 0; src1_req = 0; pin_in[0] = 0; s3_req[0] = 0; s4_req[0] = 0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 pend", pend_vec, 0);
        chk("R1 req", irq_req, 0);
        chk("R1 wake", wake, 0);

        // R10 R11 R8 priority table
        for (int i = 0; i < 8; i++) begin
            do_reset();
            wr(8'hC8, 8'h20 | (TBL[i][6] ? 8'h10 : 8'h00), 1'b1);
            fire(TBL[i][11:7]);
            chk("R10 table pend", pend_vec, TBL[i][11:7]);
            chk("R10 table req", irq_req, TBL[i][5:1]);
            chk("R11 table wake", wake, TBL[i][0]);
        end

        // R2 ignored writes, R9 latch while masked
        do_reset();
        wr(8'hC8, 8'h10, 1'b0);
        wr(8'hC9, 8'h10, 1'b1);
        fire(5'b10000);
        chk("R9 pend while masked", pend_vec, 5'b10000);
        chk("R2 bitop/addr ignored req", irq_req, 0);
        chk("R2 bitop/addr ignored wake", wake, 0);
        wr(8'hC8, 8'h9F, 1'b1);
        chk("R2 full write gen req", irq_req, 5'b10000);
        chk("R2 full write gen wake", wake, 1);

        // R3 level mode
        do_reset();
        wr(8'hC8, 8'h50, 1'b1);
        @(negedge clk); src1_req = 1; #1;
        chk("R3 level follows high", pend_vec[1], 1);
        chk("R3 level req", irq_req, 5'b00010);
        @(negedge clk); src1_req = 0; #1;
        chk("R3 level follows low", pend_vec[1], 0);

        // R4 edge mode hold, R7 ack
        do_reset();
        wr(8'hC8, 8'h10, 1'b1);
        @(negedge clk); src1_req = 1;
        @(negedge clk); src1_req = 0;
        chk("R4 edge latch", pend_vec[1], 1);
        repeat (3) @(negedge clk);
        chk("R4 edge hold", pend_vec[1], 1);
        ack_vec = 5'b00010;
        @(negedge clk); ack_vec = 0;
        chk("R7 ack clears", pend_vec[1], 0);

        // R6 timing, R7 set beats ack
        @(negedge clk); s3_req[2] = 1; #1;
        chk("R6 before edge", pend_vec[3], 0);
        @(negedge clk); s3_req[2] = 0;
        chk("R6 after one edge", pend_vec[3], 1);
        @(negedge clk); s3_req[2] = 1; ack_vec = 5'b01000;
        @(negedge clk); ack_vec = 0; s3_req[2] = 0;
        chk("R7 set wins over ack", pend_vec[3], 1);

        // R5 falling polarity, exact latency, disabled pin
        do_reset();
        wr(8'hC8, 8'h10, 1'b1);
        @(negedge clk); pin_in[0] = 1;
        repeat (5) @(negedge clk);
        chk("R5 rising ignored in fall mode", pend_vec[2], 0);
        pin_in[0] = 0;
        repeat (2) @(negedge clk);
        chk("R5 not yet after two edges", pend_vec[2], 0);
        @(negedge clk);
        chk("R5 set at third edge", pend_vec[2], 1);
        ack_vec = 5'b00100;
        @(negedge clk); ack_vec = 0;
        pin_in[1] = 1;
        repeat (5) @(negedge clk);
        pin_in[1] = 0;
        repeat (5) @(negedge clk);
        chk("R5 disabled pin ignored", pend_vec[2], 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule